// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style microcontroller core. Each cycle it receives the working-register value, a second operand (either an immediate literal or a value read from the file register space), an operation code, a destination select and a bit index. It produces the combinational result and a write strobe that routes that result either to the working register or back to the file register that supplied the operand.

Three status flags (carry, digit carry and zero) are held in a register inside the block. Each operation changes only its own fixed subset of the flags; all other flags keep their previous values. The flags load on the rising clock edge of a cycle in which the operation is marked valid. Subtraction reports carry as an inverted borrow, and the rotates pass through the carry flag, so the current carry feeds the next rotate.

Top module: `acc_alu`

## Requirements
- R1: With `op_valid` high, literal-form operations and clear-working (codes 1,3,5,7,9,16,20) assert only `w_we`. Register-form operations (codes 2,4,6,8,10-15,18,23-25) assert only `w_we` when `dest_f`=0 and only `f_we` when `dest_f`=1. Codes 17,19,21,22 assert only `f_we` whatever `dest_f` is. With `op_valid` low, or with code 0, neither strobe is asserted.
- R2: Add (code 1 literal, code 2 file) gives (W + operand) mod 256. On the next edge C takes the carry out of bit 7 and DC takes the carry out of bit 3.
- R3: Subtract (code 3 literal, code 4 file) gives operand − W in two's complement. On the next edge C = 1 exactly when W ≤ operand, and DC = 1 exactly when W[3:0] ≤ operand[3:0].
- R4: AND (5,6), OR (7,8), XOR (9,10) of W and the operand, complement of the operand (11), operand+1 (12), operand−1 (13) and move of the operand (18) produce their results and update only Z.
- R5: For every operation that updates Z, Z becomes 1 exactly when the 8-bit result is zero.
- R6: Clear-working (16) and clear-file (17) give result 0x00 and set Z to 1. C and DC are left unchanged.
- R7: Bit set (21) and bit clear (22) change only operand bit `bit_sel` (0..7), to 1 or to 0 respectively, and leave all flags unchanged.
- R8: Rotate left (23) gives {operand[6:0], C} and loads operand[7] into C. Rotate right (24) gives {C, operand[7:1]} and loads operand[0] into C. DC and Z are unchanged.
- R9: Nibble swap (25) gives {operand[3:0], operand[7:4]}. Swap, increment with skip (14, result operand+1), decrement with skip (15, result operand−1), move W to file (19, result W), move literal to W (20, result operand) and the bit operations leave all flags unchanged.
- R10: Synchronous active-high reset clears C, DC and Z to 0. Flags change only on a clock edge on which `op_valid` is high.
- R11: Op codes are 5 bits: 0 no-op, 1 add-lit, 2 add-file, 3 sub-lit, 4 sub-file, 5 and-lit, 6 and-file, 7 or-lit, 8 or-file, 9 xor-lit, 10 xor-file, 11 complement, 12 increment, 13 decrement, 14 increment-skip, 15 decrement-skip, 16 clear-W, 17 clear-file, 18 move-file, 19 move-W-to-file, 20 move-literal, 21 bit-set, 22 bit-clear, 23 rotate-left, 24 rotate-right, 25 swap. Codes 26-31 behave as no-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation select (R11) |
| w_in | input | 8 | Working-register operand |
| opnd_in | input | 8 | Literal or file-register operand |
| dest_f | input | 1 | 0 routes the result to W, 1 to the file register |
| bit_sel | input | 3 | Bit index for bit set/clear |
| result | output | 8 | ALU result |
| w_we | output | 1 | Write strobe for the working register |
| f_we | output | 1 | Write strobe for the file register |
| c_flag | output | 1 | Carry, or inverted borrow on subtraction |
| dc_flag | output | 1 | Digit carry out of the low nibble |
| z_flag | output | 1 | Zero flag |

## Verification
The hardest situations to reach are those in which a flag must be seen to hold, such as a rotate whose result is zero or a bit clear that empties the operand. A flag only shows that it held if its old value differs from the one the operation would otherwise have written. The stimulus therefore runs each such operation right after an add or a move that leaves the flags in the opposite state. The subtract cases cover W equal to the operand, and a low nibble of W above the operand's while the full byte of W is below it, so that C and DC come apart.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP     = 5'd0,
    OP_ADD_L   = 5'd1,
    OP_ADD_F   = 5'd2,
    OP_SUB_L   = 5'd3,
    OP_SUB_F   = 5'd4,
    OP_AND_L   = 5'd5,
    OP_AND_F   = 5'd6,
    OP_IOR_L   = 5'd7,
    OP_IOR_F   = 5'd8,
    OP_XOR_L   = 5'd9,
    OP_XOR_F   = 5'd10,
    OP_COM_F   = 5'd11,
    OP_INC_F   = 5'd12,
    OP_DEC_F   = 5'd13,
    OP_INCSK_F = 5'd14,
    OP_DECSK_F = 5'd15,
    OP_CLR_W   = 5'd16,
    OP_CLR_F   = 5'd17,
    OP_MOV_F   = 5'd18,
    OP_MOV_WF  = 5'd19,
    OP_MOV_L   = 5'd20,
    OP_BSET    = 5'd21,
    OP_BCLR    = 5'd22,
    OP_ROL_F   = 5'd23,
    OP_ROR_F   = 5'd24,
    OP_SWAP_F  = 5'd25
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } alu_flags_t;

endpackage

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int NIB = WIDTH / 2,
  localparam int BW  = $clog2(WIDTH)
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] w_val,
  input  logic [WIDTH-1:0] opnd,
  input  logic [BW-1:0]    bit_sel,
  input  logic             c_in,
  output logic [WIDTH-1:0] res,
  output alu_flags_t       nflags
);

  logic             is_sub;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sum;
  logic             nib_carry;
  logic [WIDTH-1:0] bmask;
  logic             rot_c;

  assign is_sub    = (op == OP_SUB_L) || (op == OP_SUB_F);
  assign addend    = is_sub ? ~w_val : w_val;
  assign sum       = {1'b0, opnd} + {1'b0, addend} + {{WIDTH{1'b0}}, is_sub};
  // carry into bit NIB is the carry out of the low nibble
  assign nib_carry = sum[NIB] ^ opnd[NIB] ^ addend[NIB];

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign bmask[i] = (bit_sel == BW'(i));
  end

  always_comb begin
    res   = opnd;
    rot_c = c_in;
    unique case (op)
      OP_ADD_L, OP_ADD_F,
      OP_SUB_L, OP_SUB_F:  res = sum[WIDTH-1:0];
      OP_AND_L, OP_AND_F:  res = w_val & opnd;
      OP_IOR_L, OP_IOR_F:  res = w_val | opnd;
      OP_XOR_L, OP_XOR_F:  res = w_val ^ opnd;
      OP_COM_F:            res = ~opnd;
      OP_INC_F, OP_INCSK_F: res = opnd + WIDTH'(1);
      OP_DEC_F, OP_DECSK_F: res = opnd - WIDTH'(1);
      OP_CLR_W, OP_CLR_F:  res = '0;
      OP_MOV_WF:           res = w_val;
      OP_BSET:             res = opnd | bmask;
      OP_BCLR:             res = opnd & ~bmask;
      OP_ROL_F: begin
        res   = {opnd[WIDTH-2:0], c_in};
        rot_c = opnd[WIDTH-1];
      end
      OP_ROR_F: begin
        res   = {c_in, opnd[WIDTH-1:1]};
        rot_c = opnd[0];
      end
      OP_SWAP_F:           res = {opnd[NIB-1:0], opnd[WIDTH-1:NIB]};
      default:             res = opnd;
    endcase
  end

  always_comb begin
    nflags.c  = (op == OP_ROL_F || op == OP_ROR_F) ? rot_c : sum[WIDTH];
    nflags.dc = nib_carry;
    nflags.z  = (res == '0);
  end

endmodule

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       op_valid,
  input  alu_op_e    op,
  input  logic       dest_f,
  output logic       w_we,
  output logic       f_we,
  output alu_flags_t upd
);

  typedef enum logic [1:0] {TGT_NONE, TGT_W, TGT_F, TGT_SEL} tgt_e;
  tgt_e tgt;

  always_comb begin
    tgt = TGT_NONE;
    upd = '0;
    unique case (op)
      OP_ADD_L, OP_SUB_L: begin tgt = TGT_W;   upd = 3'b111; end
      OP_ADD_F, OP_SUB_F: begin tgt = TGT_SEL; upd = 3'b111; end
      OP_AND_L, OP_IOR_L, OP_XOR_L, OP_CLR_W:
                          begin tgt = TGT_W;   upd.z = 1'b1; end
      OP_AND_F, OP_IOR_F, OP_XOR_F, OP_COM_F,
      OP_INC_F, OP_DEC_F, OP_MOV_F:
                          begin tgt = TGT_SEL; upd.z = 1'b1; end
      OP_CLR_F:           begin tgt = TGT_F;   upd.z = 1'b1; end
      OP_INCSK_F, OP_DECSK_F, OP_SWAP_F:
                                tgt = TGT_SEL;
      OP_ROL_F, OP_ROR_F: begin tgt = TGT_SEL; upd.c = 1'b1; end
      OP_MOV_L:                 tgt = TGT_W;
      OP_MOV_WF, OP_BSET, OP_BCLR:
                                tgt = TGT_F;
      default:                  tgt = TGT_NONE;
    endcase
  end

  assign w_we = op_valid && ((tgt == TGT_W) || ((tgt == TGT_SEL) && !dest_f));
  assign f_we = op_valid && ((tgt == TGT_F) || ((tgt == TGT_SEL) &&  dest_f));

  // R1: no write strobe when no operation is presented
  p_idle_nowrite_r1: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> (!w_we && !f_we));

  // R1: never both destinations at once
  p_one_dest_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({w_we, f_we}));

endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
  import acc_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  alu_flags_t upd,
  input  alu_flags_t nflags,
  output alu_flags_t flags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (load) begin
      if (upd.c)  flags.c  <= nflags.c;
      if (upd.dc) flags.dc <= nflags.dc;
      if (upd.z)  flags.z  <= nflags.z;
    end
  end

  // R10: flags hold on cycles with no valid operation
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(flags));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int OPW   = 5,
  localparam int BW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OPW-1:0]   op_code,
  input  logic [WIDTH-1:0] w_in,
  input  logic [WIDTH-1:0] opnd_in,
  input  logic             dest_f,
  input  logic [BW-1:0]    bit_sel,
  output logic [WIDTH-1:0] result,
  output logic             w_we,
  output logic             f_we,
  output logic             c_flag,
  output logic             dc_flag,
  output logic             z_flag
);

  alu_op_e    op_e;
  alu_flags_t upd, nflags, flags;

  assign op_e = alu_op_e'(op_code);

  acc_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .op      (op_e),
    .w_val   (w_in),
    .opnd    (opnd_in),
    .bit_sel (bit_sel),
    .c_in    (flags.c),
    .res     (result),
    .nflags  (nflags)
  );

  acc_alu_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op       (op_e),
    .dest_f   (dest_f),
    .w_we     (w_we),
    .f_we     (f_we),
    .upd      (upd)
  );

  acc_alu_flagreg u_flags (
    .clk    (clk),
    .rst    (rst),
    .load   (op_valid),
    .upd    (upd),
    .nflags (nflags),
    .flags  (flags)
  );

  assign c_flag  = flags.c;
  assign dc_flag = flags.dc;
  assign z_flag  = flags.z;

  // R3: carry after subtract is the no-borrow comparison
  p_sub_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_e == OP_SUB_L || op_e == OP_SUB_F))
    |=> (c_flag == ($past(w_in) <= $past(opnd_in))));

  // R6: clears always leave Z set
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_e == OP_CLR_W || op_e == OP_CLR_F)) |=> z_flag);

  // R8: rotates leave DC and Z alone
  p_rot_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_e == OP_ROL_F || op_e == OP_ROR_F))
    |=> $stable({dc_flag, z_flag}));

  // R9: flag-neutral operations keep all flags
  p_noflag_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_e == OP_SWAP_F || op_e == OP_INCSK_F ||
                  op_e == OP_DECSK_F || op_e == OP_MOV_WF ||
                  op_e == OP_MOV_L   || op_e == OP_BSET   || op_e == OP_BCLR))
    |=> $stable({c_flag, dc_flag, z_flag}));

endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  import acc_alu_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = 5'd0;
  logic [7:0] w_in = 8'h00, opnd_in = 8'h00;
  logic       dest_f = 1'b0;
  logic [2:0] bit_sel = 3'd0;
  logic [7:0] result;
  logic       w_we, f_we, c_flag, dc_flag, z_flag;

  int total = 0, fails = 0;
  bit done = 0;
  logic mc = 0, mdc = 0, mz = 0;   // bench model of the flags

  always #2.5 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .w_in(w_in), .opnd_in(opnd_in), .dest_f(dest_f), .bit_sel(bit_sel),
    .result(result), .w_we(w_we), .f_we(f_we),
    .c_flag(c_flag), .dc_flag(dc_flag), .z_flag(z_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    check({tag, " C"},  c_flag,  mc);
    check({tag, " DC"}, dc_flag, mdc);
    check({tag, " Z"},  z_flag,  mz);
  endtask

  // drive one valid op, check result and strobes, then the flags after the edge
  task automatic do_op(input string tag, input alu_op_e op,
                       input logic [7:0] w, input logic [7:0] o,
                       input logic d, input logic [2:0] b,
                       input logic [7:0] er, input logic ew, input logic ef,
                       input logic uc, input logic udc, input logic uz,
                       input logic nc, input logic ndc, input logic nz);
    op_valid = 1'b1; op_code = op; w_in = w; opnd_in = o; dest_f = d; bit_sel = b;
    #1;
    check({tag, " result"}, result, er);
    check({tag, " w_we"}, w_we, ew);
    check({tag, " f_we"}, f_we, ef);
    if (uc)  mc  = nc;
    if (udc) mdc = ndc;
    if (uz)  mz  = nz;
    @(posedge clk); #1;
    op_valid = 1'b0;
    check_flags(tag);
  endtask

  task automatic t_reset;
    check("R10 reset C", c_flag, 0);
    check("R10 reset DC", dc_flag, 0);
    check("R10 reset Z", z_flag, 0);
    check("R1 reset w_we", w_we, 0);
    check("R1 reset f_we", f_we, 0);
  endtask

  task automatic t_add;
    do_op("R2 add lit nib carry", OP_ADD_L, 8'h3A, 8'h0C, 0, 0, 8'h46, 1, 0, 1,1,1, 0,1,0);
    do_op("R2 R5 add file wrap",  OP_ADD_F, 8'hF0, 8'h10, 1, 0, 8'h00, 0, 1, 1,1,1, 1,0,1);
  endtask

  task automatic t_sub;
    do_op("R3 sub lit equal",     OP_SUB_L, 8'h20, 8'h20, 0, 0, 8'h00, 1, 0, 1,1,1, 1,1,1);
    do_op("R3 sub file borrow",   OP_SUB_F, 8'h21, 8'h10, 0, 0, 8'hEF, 1, 0, 1,1,1, 0,0,0);
    do_op("R3 sub file nib only", OP_SUB_F, 8'h17, 8'h35, 1, 0, 8'h1E, 0, 1, 1,1,1, 1,0,0);
  endtask

  task automatic t_dest;
    // idle cycle with a flag-changing op present: no strobes, flags hold
    op_valid = 1'b0; op_code = OP_ADD_L; w_in = 8'hFF; opnd_in = 8'h01; dest_f = 1'b1;
    #1;
    check("R1 idle w_we", w_we, 0);
    check("R1 idle f_we", f_we, 0);
    @(posedge clk); #1;
    check_flags("R10 idle hold");
    do_op("R1 literal ignores dest", OP_ADD_L, 8'h01, 8'h01, 1, 0, 8'h02, 1, 0, 1,1,1, 0,0,0);
    do_op("R1 nop no strobe", OP_NOP, 8'h55, 8'hAA, 1, 0, 8'hAA, 0, 0, 0,0,0, 0,0,0);
  endtask

  task automatic t_logic;
    do_op("R2 set carry",      OP_ADD_L, 8'h80, 8'h80, 0, 0, 8'h00, 1, 0, 1,1,1, 1,0,1);
    do_op("R4 and lit z only", OP_AND_L, 8'hF0, 8'h0F, 0, 0, 8'h00, 1, 0, 0,0,1, 0,0,1);
    do_op("R4 or file",        OP_IOR_F, 8'h12, 8'h40, 1, 0, 8'h52, 0, 1, 0,0,1, 0,0,0);
    do_op("R4 xor file",       OP_XOR_F, 8'hAA, 8'h55, 0, 0, 8'hFF, 1, 0, 0,0,1, 0,0,0);
    do_op("R4 R5 complement",  OP_COM_F, 8'h00, 8'hFF, 0, 0, 8'h00, 1, 0, 0,0,1, 0,0,1);
    do_op("R4 xor lit",        OP_XOR_L, 8'h0F, 8'h0E, 0, 0, 8'h01, 1, 0, 0,0,1, 0,0,0);
    do_op("R4 R5 inc wrap",    OP_INC_F, 8'h00, 8'hFF, 1, 0, 8'h00, 0, 1, 0,0,1, 0,0,1);
    do_op("R4 dec to zero",    OP_DEC_F, 8'h00, 8'h01, 0, 0, 8'h00, 1, 0, 0,0,1, 0,0,1);
    do_op("R4 dec wrap",       OP_DEC_F, 8'h00, 8'h00, 0, 0, 8'hFF, 1, 0, 0,0,1, 0,0,0);
    do_op("R4 R5 move test",   OP_MOV_F, 8'h77, 8'h00, 1, 0, 8'h00, 0, 1, 0,0,1, 0,0,1);
  endtask

  task automatic t_clear;
    do_op("R4 move nonzero", OP_MOV_F, 8'h00, 8'h07, 0, 0, 8'h07, 1, 0, 0,0,1, 0,0,0);
    do_op("R6 clear W",      OP_CLR_W, 8'h33, 8'h44, 1, 0, 8'h00, 1, 0, 0,0,1, 0,0,1);
    do_op("R4 move nonzero", OP_MOV_F, 8'h00, 8'h09, 0, 0, 8'h09, 1, 0, 0,0,1, 0,0,0);
    do_op("R6 clear file",   OP_CLR_F, 8'h33, 8'h9C, 0, 0, 8'h00, 0, 1, 0,0,1, 0,0,1);
  endtask

  task automatic t_noflag;
    // state now C=1 DC=0 Z=1
    do_op("R9 inc skip",   OP_INCSK_F, 8'h00, 8'hFF, 0, 0, 8'h00, 1, 0, 0,0,0, 0,0,0);
    do_op("R9 dec skip",   OP_DECSK_F, 8'h00, 8'h05, 1, 0, 8'h04, 0, 1, 0,0,0, 0,0,0);
    do_op("R9 move W->f",  OP_MOV_WF,  8'h4F, 8'h00, 0, 0, 8'h4F, 0, 1, 0,0,0, 0,0,0);
    do_op("R9 move lit",   OP_MOV_L,   8'h00, 8'h5A, 1, 0, 8'h5A, 1, 0, 0,0,0, 0,0,0);
    do_op("R11 code 30 as nop", alu_op_e'(5'd30), 8'h01, 8'h02, 1, 0, 8'h02, 0, 0, 0,0,0, 0,0,0);
  endtask

  task automatic t_bits;
    do_op("R4 move nonzero", OP_MOV_F, 8'h00, 8'h01, 0, 0, 8'h01, 1, 0, 0,0,1, 0,0,0);
    do_op("R7 set bit7",   OP_BSET, 8'h00, 8'h00, 0, 3'd7, 8'h80, 0, 1, 0,0,0, 0,0,0);
    do_op("R7 clear bit0", OP_BCLR, 8'h00, 8'hFF, 0, 3'd0, 8'hFE, 0, 1, 0,0,0, 0,0,0);
    do_op("R7 set already", OP_BSET, 8'h00, 8'h08, 1, 3'd3, 8'h08, 0, 1, 0,0,0, 0,0,0);
    do_op("R7 clear to zero", OP_BCLR, 8'h00, 8'h20, 0, 3'd5, 8'h00, 0, 1, 0,0,0, 0,0,0);
  endtask

  task automatic t_rotate;
    do_op("R2 clear carry", OP_ADD_L, 8'h01, 8'h01, 0, 0, 8'h02, 1, 0, 1,1,1, 0,0,0);
    do_op("R8 rotl",        OP_ROL_F, 8'h00, 8'hE6, 0, 0, 8'hCC, 1, 0, 1,0,0, 1,0,0);
    do_op("R8 rotr c in",   OP_ROR_F, 8'h00, 8'h01, 1, 0, 8'h80, 0, 1, 1,0,0, 1,0,0);
    do_op("R8 rotr c out0", OP_ROR_F, 8'h00, 8'h02, 0, 0, 8'h81, 1, 0, 1,0,0, 0,0,0);
    do_op("R8 rotl zero keeps Z", OP_ROL_F, 8'h00, 8'h00, 0, 0, 8'h00, 1, 0, 1,0,0, 0,0,0);
  endtask

  task automatic t_swap;
    do_op("R9 swap",      OP_SWAP_F, 8'h00, 8'h5A, 1, 0, 8'hA5, 0, 1, 0,0,0, 0,0,0);
    do_op("R9 swap zero", OP_SWAP_F, 8'h00, 8'h00, 0, 0, 8'h00, 1, 0, 0,0,0, 0,0,0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_dest();
    t_logic();
    t_clear();
    t_noflag();
    t_bits();
    t_rotate();
    t_swap();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule